// File: doc/BRIEF.md
# Earliest-Timestamp Partition Bus Arbiter

This block arbitrates one source partition bus shared by a parameterised number of traffic nodes. Each node offers a ready flag, a 2-bit relative timestamp, a 64-bit packet and an 8-bit next-hop address. The node holding the earliest packet wins the bus. The block drives a one-hot grant vector, and that vector steers the winner's packet and next hop onto the bus output through an AND-OR multiplexer. There is no binary index anywhere in the path.

The 2-bit timestamp each node presents is bits [2:1] of the packet's timestamp minus (current time minus 6). Within that window a plain unsigned compare orders the packets: 0 is the earliest and 3 the latest. The grant and the multiplexed outputs are registered, so they appear one clock after the inputs they were chosen from.

When the consumer takes the bus word, the block sends a dequeue pulse back to the granted node alone. It also leaves that node out of the selection made at the same edge, so a packet cannot be granted twice while the node updates its head.

Top module: `ts_bus_arbiter`

## Requirements
- R1: While reset is low (synchronous, active low), and on the first outputs after it, `grant`, `bus_valid`, `bus_pkt` and `bus_hop` are all zero.
- R2: `grant` has one bit per node. Bit i marks node i, and at most one bit is ever set.
- R3: A node can be granted only if its `node_ready` bit was 1 at the sampling edge. If no eligible node is ready, `grant` is zero and `bus_valid` is low.
- R4: Among the eligible nodes, the grant goes to the one with the smallest 2-bit timestamp, compared as an unsigned number. Node i's timestamp is `node_ts[2i+1:2i]`.
- R5: When several eligible nodes share the smallest timestamp, the node with the lowest index wins.
- R6: `bus_pkt` and `bus_hop` carry the granted node's packet (`node_pkt[64i+63:64i]`) and next hop (`node_hop[8i+7:8i]`). Both are zero while `bus_valid` is low.
- R7: `grant`, `bus_valid`, `bus_pkt` and `bus_hop` are registered. They reflect the inputs present at the previous rising clock edge and stay unchanged between edges.
- R8: `node_deq` equals `grant` in any cycle where both `bus_take` and `bus_valid` are 1, and is zero otherwise. It is combinational.
- R9: A node whose `node_deq` bit is 1 in a cycle is not eligible for the selection registered at the end of that cycle, even if its ready bit is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| node_ready | input | N_NODES | Per-node packet-available flag |
| node_ts | input | 2*N_NODES | Per-node 2-bit relative timestamp |
| node_pkt | input | 64*N_NODES | Per-node head packet |
| node_hop | input | 8*N_NODES | Per-node next-hop address |
| bus_take | input | 1 | Consumer accepts the current bus word |
| grant | output | N_NODES | Registered one-hot grant |
| bus_valid | output | 1 | Bus word is valid |
| bus_pkt | output | 64 | Packet of the granted node |
| bus_hop | output | 8 | Next hop of the granted node |
| node_deq | output | N_NODES | Dequeue pulse to the granted node |

## Verification
A faulty comparator or tie-break shows up one clock after the inputs are applied. Either the grant bit sits at the wrong index or the bus packet belongs to the wrong node, and because every node carries a distinct packet, both mistakes are visible at the ports. A stale dequeue mask shows up as a second grant to the node that was just dequeued, at the very next edge. A register that goes transparent shows up as outputs changing before the edge.

// File: rtl/ts_bus_arbiter.sv
module ts_bus_arbiter #(
  parameter int N_NODES = 8,
  parameter int PKT_W   = 64,
  parameter int HOP_W   = 8,
  parameter int TS_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_NODES-1:0]       node_ready,
  input  logic [N_NODES*TS_W-1:0]  node_ts,
  input  logic [N_NODES*PKT_W-1:0] node_pkt,
  input  logic [N_NODES*HOP_W-1:0] node_hop,
  input  logic                     bus_take,
  output logic [N_NODES-1:0]       grant,
  output logic                     bus_valid,
  output logic [PKT_W-1:0]         bus_pkt,
  output logic [HOP_W-1:0]         bus_hop,
  output logic [N_NODES-1:0]       node_deq
);

  logic [N_NODES-1:0] elig, sel;
  logic [TS_W-1:0]    min_ts;
  logic               any_elig;
  logic [PKT_W-1:0]   mux_pkt;
  logic [HOP_W-1:0]   mux_hop;

  assign node_deq = grant & {N_NODES{bus_take & bus_valid}};
  assign elig     = node_ready & ~node_deq;

  always_comb begin
    min_ts   = '0;
    any_elig = 1'b0;
    for (int i = 0; i < N_NODES; i++) begin
      if (elig[i] && (!any_elig || node_ts[i*TS_W +: TS_W] < min_ts)) begin
        min_ts   = node_ts[i*TS_W +: TS_W];
        any_elig = 1'b1;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (elig[i] && node_ts[i*TS_W +: TS_W] == min_ts && sel == '0)
        sel[i] = 1'b1;
    end
  end

  always_comb begin
    mux_pkt = '0;
    mux_hop = '0;
    for (int i = 0; i < N_NODES; i++) begin
      mux_pkt = mux_pkt | ({PKT_W{sel[i]}} & node_pkt[i*PKT_W +: PKT_W]);
      mux_hop = mux_hop | ({HOP_W{sel[i]}} & node_hop[i*HOP_W +: HOP_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= '0;
      bus_valid <= 1'b0;
      bus_pkt   <= '0;
      bus_hop   <= '0;
    end else begin
      grant     <= sel;
      bus_valid <= any_elig;
      bus_pkt   <= mux_pkt;
      bus_hop   <= mux_hop;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid == (grant != '0)); // R3

  AST_GRANT_WAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & $past(node_ready & ~node_deq)) != '0)); // R9

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_pkt == '0 && bus_hop == '0)); // R6

  AST_DEQ_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (node_deq != '0) |-> (bus_take && (node_deq & ~grant) == '0)); // R8

endmodule

// File: tb/tb_ts_bus_arbiter.sv
module tb_ts_bus_arbiter;
  localparam int N = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     node_ready = '0;
  logic [N*2-1:0]   node_ts = '0;
  logic [N*64-1:0]  node_pkt;
  logic [N*8-1:0]   node_hop;
  logic             bus_take = 1'b0;
  logic [N-1:0]     grant, node_deq;
  logic             bus_valid;
  logic [63:0]      bus_pkt;
  logic [7:0]       bus_hop;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ts_bus_arbiter #(.N_NODES(N)) dut (
    .clk(clk), .rst_n(rst_n), .node_ready(node_ready), .node_ts(node_ts),
    .node_pkt(node_pkt), .node_hop(node_hop), .bus_take(bus_take),
    .grant(grant), .bus_valid(bus_valid), .bus_pkt(bus_pkt),
    .bus_hop(bus_hop), .node_deq(node_deq));

  function automatic logic [63:0] pkt_of(int i);
    return {32'hC0DE_0000 + 32'(i), 32'(i * 977 + 13)};
  endfunction

  function automatic logic [7:0] hop_of(int i);
    return 8'h40 + 8'(i * 3);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      node_pkt[i*64 +: 64] = pkt_of(i);
      node_hop[i*8 +: 8]   = hop_of(i);
    end
  end

  function automatic int expect_idx(logic [N-1:0] rdy, logic [N*2-1:0] ts, logic [N-1:0] mask);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (rdy[i] && !mask[i] && (best < 0 || ts[i*2 +: 2] < ts[best*2 +: 2])) best = i;
    return best;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(int idx, string req);
    logic [N-1:0] eg = (idx < 0) ? '0 : (N'(1) << idx);
    check(grant == eg, req, 64'(grant), 64'(eg));
    check(bus_valid == (idx >= 0), req, 64'(bus_valid), 64'(idx >= 0));
    check(bus_pkt == ((idx < 0) ? 64'd0 : pkt_of(idx)), {req, " R6 pkt"}, bus_pkt,
          (idx < 0) ? 64'd0 : pkt_of(idx));
    check(bus_hop == ((idx < 0) ? 8'd0 : hop_of(idx)), {req, " R6 hop"}, 64'(bus_hop),
          64'((idx < 0) ? 8'd0 : hop_of(idx)));
  endtask

  task automatic apply(logic [N-1:0] rdy, logic [N*2-1:0] ts);
    @(negedge clk);
    node_ready = rdy;
    node_ts = ts;
    bus_take = 1'b0;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [N*2-1:0] ts_all(logic [1:0] v);
    logic [N*2-1:0] r;
    for (int i = 0; i < N; i++) r[i*2 +: 2] = v;
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    node_ready = '1;
    repeat (3) @(posedge clk);
    #2;
    check_out(-1, "R1 in reset");
    @(negedge clk);
    node_ready = '0;
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check_out(-1, "R1 after reset");
  endtask

  task automatic t_none_ready();
    apply('0, ts_all(2'd0));
    check_out(-1, "R3 none ready");
  endtask

  task automatic t_single();
    apply(8'b0010_0000, ts_all(2'd3));
    check_out(5, "R3 single ready");
  endtask

  task automatic t_earliest();
    logic [N*2-1:0] ts = ts_all(2'd3);
    ts[1*2 +: 2] = 2'd3;
    ts[3*2 +: 2] = 2'd1;
    ts[6*2 +: 2] = 2'd2;
    ts[4*2 +: 2] = 2'd0;
    apply(8'b0100_1010, ts);
    check_out(3, "R4 smallest ts");
    apply(8'b0101_1010, ts);
    check_out(4, "R4 ts zero wins");
  endtask

  task automatic t_tie();
    logic [N*2-1:0] ts = ts_all(2'd2);
    ts[2*2 +: 2] = 2'd0;
    ts[6*2 +: 2] = 2'd0;
    apply(8'b0100_0100, ts);
    check_out(2, "R5 tie lowest index");
    apply('1, ts_all(2'd3));
    check_out(0, "R5 all tied");
  endtask

  task automatic t_latency();
    logic [N*2-1:0] ts = ts_all(2'd1);
    apply(8'b1000_0000, ts);
    check_out(7, "R7 first pattern");
    @(negedge clk);
    node_ready = 8'b0000_0010;
    #5;
    check_out(7, "R7 held before edge");
    @(posedge clk);
    #2;
    check_out(1, "R7 after edge");
  endtask

  task automatic t_dequeue();
    logic [N*2-1:0] ts = ts_all(2'd2);
    ts[3*2 +: 2] = 2'd0;
    ts[5*2 +: 2] = 2'd1;
    apply(8'b0010_1001, ts);
    check_out(3, "R4 before dequeue");
    @(negedge clk);
    bus_take = 1'b1;
    #1;
    check(node_deq == 8'b0000_1000, "R8 deq to grant", 64'(node_deq), 64'h08);
    @(posedge clk);
    #2;
    check_out(5, "R9 dequeued node skipped");
    @(negedge clk);
    bus_take = 1'b0;
    #1;
    check(node_deq == '0, "R8 no take no deq", 64'(node_deq), 64'h0);
    node_ready = '0;
    @(posedge clk);
    #2;
    @(negedge clk);
    bus_take = 1'b1;
    #1;
    check(node_deq == '0, "R8 take while invalid", 64'(node_deq), 64'h0);
    bus_take = 1'b0;
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0]   r = N'($urandom);
      logic [N*2-1:0] t = (N*2)'($urandom);
      apply(r, t);
      check_out(expect_idx(r, t, '0), "R4 R5 random");
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_none_ready();
    t_single();
    t_earliest();
    t_tie();
    t_latency();
    t_dequeue();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule